// File: doc/BRIEF.md
# Hardware Task Switch Sequencer

This block is the multi-cycle engine that moves a protected-mode CPU model from one task to another. A far jump, a far call, an interrupt or a nested return selects a new task. The surrounding core gives the block a parallel snapshot of the running task's registers, the current task-register selector, base and limit, and the already-resolved descriptor of the target task (selector, base, limit, type). The block then works through a sequence of doubleword accesses on a single memory port. It saves the outgoing state into the outgoing task record. For a nesting switch it writes a back-link into the incoming record. Last, it reads the incoming record and presents the reloaded register file, the new task register, the page-directory base, the local table selector and a debug-trap request.

Before any memory access, the block checks the target. A target whose limit cannot hold the fixed 104-byte record, or whose busy state does not suit the cause of the switch, ends the sequence with a one-cycle fault pulse. The block also reports the descriptor type values the core must write back: the busy value for the incoming descriptor, and either the busy or the available value for the outgoing one. The snapshot and descriptor inputs must stay stable from start until done or fault.

Top module: `task_switch_seq`

## Requirements
- R1: When `start` is high in idle and `tgt_limit` is below MIN_LIMIT (103, meaning the last byte offset 67H), `fault` pulses for one cycle on the next clock edge and no memory access is made.
- R2: For cause JMP (00), CALL (01) or INT (10), a target type other than 9 (available), including 0BH (busy), faults with no memory write.
- R3: The outgoing state is written as 16 doublewords at outgoing base + 20H, +24H, …, +5CH. The order is EIP, EFLAGS, EAX, ECX, EDX, EBX, ESP, EBP, ESI, EDI, ES, CS, SS, DS, FS, GS. Each selector is zero-extended from 16 to 32 bits.
- R4: The block never writes outgoing offsets 00H–1CH or 60H–64H. Apart from the link word in R5, it never writes the incoming record.
- R5: For CALL or INT, the doubleword {16'h0, cur_tr_sel} is written to incoming offset 00H, and the loaded EFLAGS has bit NT_BIT (14) forced to 1.
- R6: The incoming record is read from offset 1CH to 64H. `new_cr3` comes from 1CH. EIP, EFLAGS, the eight general registers and the six selectors (low 16 bits) come from 20H–5CH, in the same order as R3. `new_ldtr` comes from the low 16 bits of 60H.
- R7: `dbg_trap` equals bit 0 of the incoming doubleword at offset 64H.
- R8: At done, `new_type` is 0BH. `old_type` is 9 for JMP and return, and 0BH for CALL and INT. `new_tr_sel/base/limit` equal the target descriptor.
- R9: For a return (cause 11), the target must have type 0BH, or the block faults with no memory access. The block reads the outgoing offset 00H and faults with no write if its low 16 bits differ from `tgt_sel`. Otherwise, the saved EFLAGS has bit 14 cleared.
- R10: `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ready`. `done` is a one-cycle pulse in the cycle after the last read is accepted.
- R11: After reset, `mem_valid`, `done`, `fault`, `dbg_trap` and all new-state outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a switch (honoured in idle) |
| cause | input | 2 | 00 JMP, 01 CALL, 10 INT, 11 nested return |
| cur_eip | input | 32 | Outgoing instruction pointer |
| cur_eflags | input | 32 | Outgoing flags |
| cur_gpr | input | 256 | Outgoing EAX..EDI, EAX in bits 31:0 |
| cur_seg | input | 96 | Outgoing ES,CS,SS,DS,FS,GS, ES in bits 15:0 |
| cur_tr_sel | input | 16 | Outgoing task selector |
| cur_tr_base | input | 32 | Outgoing record base |
| cur_tr_limit | input | 32 | Outgoing record limit |
| tgt_sel | input | 16 | Target task selector |
| tgt_base | input | 32 | Target record base |
| tgt_limit | input | 32 | Target record limit |
| tgt_type | input | 4 | Target descriptor type |
| mem_valid | output | 1 | Access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the doubleword |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access accepted |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| done | output | 1 | Switch complete pulse |
| fault | output | 1 | Switch rejected pulse |
| new_eip | output | 32 | Loaded instruction pointer |
| new_eflags | output | 32 | Loaded flags |
| new_gpr | output | 256 | Loaded general registers |
| new_seg | output | 96 | Loaded selectors |
| new_cr3 | output | 32 | Loaded page-directory base |
| new_ldtr | output | 16 | Loaded local table selector |
| new_tr_sel | output | 16 | New task selector |
| new_tr_base | output | 32 | New record base |
| new_tr_limit | output | 32 | New record limit |
| new_type | output | 4 | Type to write to incoming descriptor |
| old_type | output | 4 | Type to write to outgoing descriptor |
| dbg_trap | output | 1 | Debug trap before first new instruction |

## Verification
The bench builds the block with the default MIN_LIMIT of 103 and NT_BIT of 14. With these values, the limit boundary can be driven directly: a limit of 66H must fault and 67H must pass. The nested flag sits at the architectural position, so a call followed by a return forms a real link chain through memory. Random ready stalls exercise the held-request rule between every pair of accesses.

// File: rtl/task_switch_seq.sv
module task_switch_seq #(
  parameter int MIN_LIMIT = 103,
  parameter int NT_BIT    = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   cause,
  input  logic [31:0]  cur_eip,
  input  logic [31:0]  cur_eflags,
  input  logic [255:0] cur_gpr,
  input  logic [95:0]  cur_seg,
  input  logic [15:0]  cur_tr_sel,
  input  logic [31:0]  cur_tr_base,
  input  logic [31:0]  cur_tr_limit,
  input  logic [15:0]  tgt_sel,
  input  logic [31:0]  tgt_base,
  input  logic [31:0]  tgt_limit,
  input  logic [3:0]   tgt_type,
  output logic         mem_valid,
  output logic         mem_we,
  output logic [31:0]  mem_addr,
  output logic [31:0]  mem_wdata,
  input  logic         mem_ready,
  input  logic [31:0]  mem_rdata,
  output logic         done,
  output logic         fault,
  output logic [31:0]  new_eip,
  output logic [31:0]  new_eflags,
  output logic [255:0] new_gpr,
  output logic [95:0]  new_seg,
  output logic [31:0]  new_cr3,
  output logic [15:0]  new_ldtr,
  output logic [15:0]  new_tr_sel,
  output logic [31:0]  new_tr_base,
  output logic [31:0]  new_tr_limit,
  output logic [3:0]   new_type,
  output logic [3:0]   old_type,
  output logic         dbg_trap
);
  localparam logic [3:0] TY_AVAIL = 4'h9;
  localparam logic [3:0] TY_BUSY  = 4'hB;
  localparam logic [4:0] SAVE_LAST = 5'd15;
  localparam logic [4:0] LOAD_LAST = 5'd18;

  typedef enum logic [2:0] {S_IDLE, S_LINKRD, S_SAVE, S_LINKWR, S_LOAD} st_t;
  st_t st;
  logic [4:0] idx;
  logic [1:0] cause_q;
  logic [31:0] sv [16];

  wire is_ret   = (cause == 2'b11);
  wire nest_q   = (cause_q == 2'b01) || (cause_q == 2'b10);
  wire ret_q    = (cause_q == 2'b11);
  wire bad_lim  = tgt_limit < 32'(MIN_LIMIT);
  wire bad_type = is_ret ? (tgt_type != TY_BUSY) : (tgt_type != TY_AVAIL);
  wire xfer     = mem_valid && mem_ready;
  wire [31:0] off = {25'd0, idx, 2'b00};

  assign mem_valid = (st != S_IDLE);
  assign mem_we    = (st == S_SAVE) || (st == S_LINKWR);

  always_comb begin
    sv[0] = cur_eip;
    sv[1] = cur_eflags;
    if (ret_q) sv[1][NT_BIT] = 1'b0;
    for (int i = 0; i < 8; i++) sv[i+2] = cur_gpr[32*i +: 32];
    for (int i = 0; i < 6; i++) sv[i+10] = {16'h0, cur_seg[16*i +: 16]};
  end

  always_comb begin
    mem_addr  = 32'h0;
    mem_wdata = 32'h0;
    case (st)
      S_LINKRD: mem_addr = cur_tr_base;
      S_SAVE: begin
        mem_addr  = cur_tr_base + 32'h20 + off;
        mem_wdata = sv[idx[3:0]];
      end
      S_LINKWR: begin
        mem_addr  = tgt_base;
        mem_wdata = {16'h0, cur_tr_sel};
      end
      S_LOAD: mem_addr = tgt_base + 32'h1C + off;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; cause_q <= '0;
      done <= 1'b0; fault <= 1'b0;
      new_eip <= '0; new_eflags <= '0; new_gpr <= '0; new_seg <= '0;
      new_cr3 <= '0; new_ldtr <= '0; new_tr_sel <= '0; new_tr_base <= '0;
      new_tr_limit <= '0; new_type <= '0; old_type <= '0; dbg_trap <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cause_q <= cause;
          idx     <= '0;
          if (bad_lim || bad_type) fault <= 1'b1;
          else st <= is_ret ? S_LINKRD : S_SAVE;
        end
        S_LINKRD: if (xfer) begin
          if (mem_rdata[15:0] != tgt_sel) begin
            fault <= 1'b1;
            st    <= S_IDLE;
          end else st <= S_SAVE;
        end
        S_SAVE: if (xfer) begin
          if (idx == SAVE_LAST) begin
            idx <= '0;
            st  <= nest_q ? S_LINKWR : S_LOAD;
          end else idx <= idx + 5'd1;
        end
        S_LINKWR: if (xfer) st <= S_LOAD;
        S_LOAD: if (xfer) begin
          case (idx)
            5'd0: new_cr3 <= mem_rdata;
            5'd1: new_eip <= mem_rdata;
            5'd2: begin
              new_eflags <= mem_rdata;
              if (nest_q) new_eflags[NT_BIT] <= 1'b1;
            end
            5'd17: new_ldtr <= mem_rdata[15:0];
            5'd18: dbg_trap <= mem_rdata[0];
            default: ;
          endcase
          for (int i = 0; i < 8; i++)
            if (idx == 5'(i + 3)) new_gpr[32*i +: 32] <= mem_rdata;
          for (int i = 0; i < 6; i++)
            if (idx == 5'(i + 11)) new_seg[16*i +: 16] <= mem_rdata[15:0];
          if (idx == LOAD_LAST) begin
            st           <= S_IDLE;
            done         <= 1'b1;
            new_tr_sel   <= tgt_sel;
            new_tr_base  <= tgt_base;
            new_tr_limit <= tgt_limit;
            new_type     <= TY_BUSY;
            old_type     <= nest_q ? TY_BUSY : TY_AVAIL;
          end else idx <= idx + 5'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> (mem_addr == tgt_base) ||
      ((mem_addr - cur_tr_base) >= 32'h20 && (mem_addr - cur_tr_base) <= 32'h5C));

  // R2
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && start && cause != 2'b11 && tgt_type == TY_BUSY |=> fault && !mem_valid);

  // R5
  nest_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && nest_q |-> new_eflags[NT_BIT]);

  // R1
  limit_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && start && bad_lim |=> fault && !mem_valid);
endmodule

// File: tb/tb_task_switch_seq.sv
module tb_task_switch_seq;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] cause = 0;
  logic [31:0] cur_eip = 0, cur_eflags = 0, cur_tr_base = 0, cur_tr_limit = 0;
  logic [255:0] cur_gpr = 0;
  logic [95:0] cur_seg = 0;
  logic [15:0] cur_tr_sel = 0, tgt_sel = 0;
  logic [31:0] tgt_base = 0, tgt_limit = 0;
  logic [3:0] tgt_type = 0;
  logic mem_valid, mem_we, mem_ready = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic done, fault, dbg_trap;
  logic [31:0] new_eip, new_eflags, new_cr3, new_tr_base, new_tr_limit;
  logic [255:0] new_gpr;
  logic [95:0] new_seg;
  logic [15:0] new_ldtr, new_tr_sel;
  logic [3:0] new_type, old_type;

  logic [31:0] mem [256];
  logic [31:0] exp_m [256];
  int wr_cnt = 0, acc_cnt = 0, n_chk = 0, n_fail = 0, cyc = 0;

  task_switch_seq dut (.*);

  always #(CLK_P/2) clk = ~clk;
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_valid && mem_ready) begin
    acc_cnt <= acc_cnt + 1;
    if (mem_we) begin mem[mem_addr[9:2]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
  end
  always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

  task automatic chk(input bit ok, input string req, input [63:0] act, input [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [31:0] save_w(input int i, input logic [1:0] c);
    logic [31:0] w;
    if (i == 0) w = cur_eip;
    else if (i == 1) begin w = cur_eflags; if (c == 2'b11) w[14] = 1'b0; end
    else if (i < 10) w = cur_gpr[32*(i-2) +: 32];
    else w = {16'h0, cur_seg[16*(i-10) +: 16]};
    return w;
  endfunction

  task automatic do_sw(input logic [1:0] c, input logic [31:0] cb, input logic [15:0] cs,
                       input logic [31:0] tb, input logic [15:0] ts, input logic [3:0] ty,
                       input logic [31:0] tl, input bit exp_fault, input int exp_acc,
                       input string tag);
    int w0, a0, tw, mism;
    bit seen;
    cur_eip = $urandom; cur_eflags = $urandom;
    for (int i = 0; i < 8; i++) cur_gpr[32*i +: 32] = $urandom;
    for (int i = 0; i < 6; i++) cur_seg[16*i +: 16] = 16'($urandom);
    for (int i = 0; i < 256; i++) exp_m[i] = mem[i];
    w0 = wr_cnt; a0 = acc_cnt;
    @(negedge clk);
    cause = c; cur_tr_base = cb; cur_tr_sel = cs; cur_tr_limit = 32'h67;
    tgt_base = tb; tgt_sel = ts; tgt_type = ty; tgt_limit = tl; start = 1;
    @(negedge clk);
    start = 0;
    seen = 0;
    for (int n = 0; n < 3000; n++) begin
      if (done || fault) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, {tag, " R10 completion"}, 64'(seen), 1);
    if (exp_fault) begin
      chk(fault && !done, {tag, " fault flag"}, {62'd0, fault, done}, 2);
      chk(wr_cnt == w0, {tag, " R2 no writes on fault"}, 64'(wr_cnt - w0), 0);
      chk(acc_cnt - a0 == exp_acc, {tag, " R1 R9 access count on fault"}, 64'(acc_cnt - a0), 64'(exp_acc));
    end else begin
      for (int i = 0; i < 16; i++) exp_m[cb/4 + 8 + i] = save_w(i, c);
      if (c == 2'b01 || c == 2'b10) exp_m[tb/4] = {16'h0, cs};
      tw = tb / 4;
      chk(done && !fault, {tag, " R10 done"}, {62'd0, done, fault}, 2);
      chk(wr_cnt - w0 == ((c == 2'b01 || c == 2'b10) ? 17 : 16), {tag, " R3 R5 write count"},
          64'(wr_cnt - w0), 64'((c == 2'b01 || c == 2'b10) ? 17 : 16));
      chk(new_cr3 == exp_m[tw+7], {tag, " R6 cr3"}, 64'(new_cr3), 64'(exp_m[tw+7]));
      chk(new_eip == exp_m[tw+8], {tag, " R6 eip"}, 64'(new_eip), 64'(exp_m[tw+8]));
      begin
        logic [31:0] ef;
        ef = exp_m[tw+9];
        if (c == 2'b01 || c == 2'b10) ef[14] = 1'b1;
        chk(new_eflags == ef, {tag, " R5 R6 eflags"}, 64'(new_eflags), 64'(ef));
      end
      for (int i = 0; i < 8; i++)
        chk(new_gpr[32*i +: 32] == exp_m[tw+10+i], {tag, " R6 gpr"}, 64'(new_gpr[32*i +: 32]), 64'(exp_m[tw+10+i]));
      for (int i = 0; i < 6; i++)
        chk(new_seg[16*i +: 16] == exp_m[tw+18+i][15:0], {tag, " R6 seg"}, 64'(new_seg[16*i +: 16]), 64'(exp_m[tw+18+i][15:0]));
      chk(new_ldtr == exp_m[tw+24][15:0], {tag, " R6 ldtr"}, 64'(new_ldtr), 64'(exp_m[tw+24][15:0]));
      chk(dbg_trap == exp_m[tw+25][0], {tag, " R7 trap"}, 64'(dbg_trap), 64'(exp_m[tw+25][0]));
      chk(new_type == 4'hB, {tag, " R8 new type"}, 64'(new_type), 64'hB);
      chk(old_type == ((c == 2'b01 || c == 2'b10) ? 4'hB : 4'h9), {tag, " R8 old type"},
          64'(old_type), 64'((c == 2'b01 || c == 2'b10) ? 4'hB : 4'h9));
      chk(new_tr_sel == ts && new_tr_base == tb && new_tr_limit == tl, {tag, " R8 tr"},
          {new_tr_sel, new_tr_base[15:0]}, {ts, tb[15:0]});
    end
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_m[i]) mism++;
    chk(mism == 0, {tag, " R3 R4 memory image"}, 64'(mism), 0);
    @(negedge clk);
    chk(!done && !fault, {tag, " R10 single-cycle pulse"}, {62'd0, done, fault}, 0);
  endtask

  initial begin
    logic [31:0] bases [4];
    void'($urandom(32'd20240611));
    bases[0] = 32'h000; bases[1] = 32'h100; bases[2] = 32'h200; bases[3] = 32'h300;
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    chk(!mem_valid && !done && !fault && !dbg_trap, "R11 reset handshake", {61'd0, mem_valid, done, fault}, 0);
    chk(new_eip == 0 && new_cr3 == 0 && new_gpr == 0 && new_tr_sel == 0, "R11 reset state", 64'(new_eip | new_cr3), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!mem_valid, "R11 idle after reset", 64'(mem_valid), 0);

    mem[32'h100/4 + 25] = 32'h0;
    do_sw(2'b00, 32'h000, 16'h0028, 32'h100, 16'h0030, 4'h9, 32'h67, 0, 0, "jmp boundary-limit");
    mem[32'h200/4 + 25] = 32'h1;
    do_sw(2'b01, 32'h100, 16'h0030, 32'h200, 16'h0038, 4'h9, 32'h67, 0, 0, "call trap-set R7");
    do_sw(2'b11, 32'h200, 16'h0038, 32'h100, 16'h0030, 4'hB, 32'h67, 0, 0, "return R9");
    do_sw(2'b10, 32'h000, 16'h0028, 32'h300, 16'h0040, 4'h9, 32'hFF, 0, 0, "interrupt R5");
    do_sw(2'b00, 32'h000, 16'h0028, 32'h100, 16'h0030, 4'hB, 32'h67, 1, 0, "jmp busy R2");
    do_sw(2'b01, 32'h000, 16'h0028, 32'h100, 16'h0030, 4'hB, 32'h67, 1, 0, "call busy R2");
    do_sw(2'b00, 32'h000, 16'h0028, 32'h100, 16'h0030, 4'h9, 32'h66, 1, 0, "short limit R1");
    do_sw(2'b11, 32'h000, 16'h0028, 32'h100, 16'h0030, 4'h9, 32'h67, 1, 0, "return to available R9");
    mem[0] = 32'hABCD_0048;
    do_sw(2'b11, 32'h000, 16'h0028, 32'h100, 16'h0030, 4'hB, 32'h67, 1, 1, "return link mismatch R9");

    for (int k = 0; k < 24; k++) begin
      int ci, ti;
      logic [1:0] c;
      ci = $urandom % 4;
      ti = (ci + 1 + ($urandom % 3)) % 4;
      c = 2'($urandom % 4);
      mem[bases[ti]/4 + 25] = $urandom;
      if (c == 2'b11) begin
        mem[bases[ci]/4] = {16'($urandom), 16'(16'h0008 * (ti + 5))};
        do_sw(c, bases[ci], 16'(16'h0008 * (ci + 5)), bases[ti], 16'(16'h0008 * (ti + 5)), 4'hB,
              32'h67 + ($urandom % 64), 0, 0, "random return R9");
      end else begin
        do_sw(c, bases[ci], 16'(16'h0008 * (ci + 5)), bases[ti], 16'(16'h0008 * (ti + 5)), 4'h9,
              32'h67 + ($urandom % 64), 0, 0, "random switch R3");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule